// File: doc/BRIEF.md
# Grouped Shift-Add FIR Filter

This block is a fixed-coefficient FIR filter. It uses no multipliers, and its structure is set at compile time by a group size `L`. Each accepted sample is scaled by every coefficient through shift-add networks. The products are gathered into groups. Inside each group, the products are summed by a narrow, unregistered binary adder tree. Each group sum then enters a registered accumulation chain through one structural adder.

With `L = 1` the chain registers every product, which gives the transposed form. With `L = N_TAPS` there is a single group, so the accumulation path has no registers apart from the output stage, which gives the direct form. With `L = 2` the block uses a pairing mode. Tap 0 stands alone and the remaining taps are paired `{1,2}`, `{3,4}` and so on. As a result, mirrored coefficients of a linear-phase set land on the same delayed input column. Each distinct coefficient magnitude within a column is built once, and its sign is applied afterwards.

A sample enters when `valid_i` is high. The state advances only on such cycles, so the sample index counts accepted samples, not clock cycles.

Top module: `fir_grouped`

## Requirements
- R1: One cycle after an accepted sample x[n], `y_o` equals the exact sum over k of COEF[k]·x[n−k], where the sample index counts accepted samples.
- R2: `valid_o` equals `valid_i` of the previous clock cycle, and `y_o` changes only in the cycle that follows an accepted sample.
- R3: A cycle with `valid_i` low does not change `y_o` or any internal history, and the value on `x_i` during that cycle has no effect on later outputs.
- R4: While `rst_ni` is low, `valid_o` and `y_o` read 0. After release, every sample from before the reset counts as zero.
- R5: With `L = 1` (transposed form) the outputs follow R1.
- R6: With `L = 2` (tap 0 alone, then taps paired {1,2}, {3,4}, …) the outputs follow R1.
- R7: With `L = 4` on 9 taps (groups {0..3}, {4..7}, {8}, the last group short) the outputs follow R1.
- R8: `y_o` is W_X + ceil(log2 Σ|COEF|) + 1 bits wide, and full-scale input patterns of either sign produce the exact result without wrap-around.
- R9: With `L = N_TAPS` (one group, direct form) the outputs follow R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe |
| x_i | input | W_X | Signed input sample |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| y_o | output | W_Y | Signed full-precision filter output |

## Verification
The bench builds four copies of the block with a symmetric 9-tap coefficient set and group sizes 1, 2, 4 and 9, and feeds them the same stimulus. These cover the transposed form, the pairing mode with shared mirrored multipliers, the generic grouping with a short final group, and the single-group direct form. A behavioural convolution over the accepted-sample history is compared against all four copies every cycle. The stimulus includes impulses, random data, idle gaps with random data on `x_i`, full-scale patterns of both signs, and a reset in the middle of a run.

// File: rtl/fir_grp_pkg.sv
package fir_grp_pkg;
  localparam int MAX_TAPS = 16;
  typedef int coef_t [MAX_TAPS];

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int abs_sum(input coef_t c, input int lo, input int hi);
    int s;
    s = 0;
    for (int k = lo; k <= hi; k++) s += iabs(c[k]);
    return s;
  endfunction

  function automatic int acc_width(input int wx, input int s);
    return wx + $clog2(s) + 1;
  endfunction

  function automatic bit pair_mode(input int l);
    return l == 2;
  endfunction

  function automatic int num_groups(input int nt, input int l);
    return pair_mode(l) ? 1 + nt / 2 : (nt + l - 1) / l;
  endfunction

  function automatic int num_cols(input int l);
    return pair_mode(l) ? 2 : l;
  endfunction

  function automatic int grp_first(input int g, input int l);
    if (pair_mode(l)) return (g == 0) ? 0 : 2 * g - 1;
    return g * l;
  endfunction

  function automatic int grp_last(input int g, input int nt, input int l);
    int e;
    e = pair_mode(l) ? ((g == 0) ? 0 : 2 * g) : g * l + l - 1;
    return (e > nt - 1) ? nt - 1 : e;
  endfunction

  // column = input delay in samples seen by this tap's multiplier
  function automatic int tap_col(input int k, input int l);
    if (pair_mode(l)) return (k == 0) ? 0 : (k - 1) % 2;
    return k % l;
  endfunction

  // lowest tap on the same column with equal magnitude builds the product
  function automatic int tap_owner(input coef_t c, input int k, input int l);
    for (int j = 0; j < k; j++)
      if (tap_col(j, l) == tap_col(k, l) && iabs(c[j]) == iabs(c[k])) return j;
    return k;
  endfunction
endpackage

// File: rtl/fir_col_delay.sv
module fir_col_delay #(
  parameter int W_X    = 8,
  parameter int N_COLS = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic signed [W_X-1:0] x_i,
  output logic signed [W_X-1:0] col_o [N_COLS]
);
  assign col_o[0] = x_i;

  if (N_COLS > 1) begin : g_line
    logic signed [W_X-1:0] q [N_COLS-1];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < N_COLS - 1; i++) q[i] <= '0;
      end else if (en_i) begin
        q[0] <= x_i;
        for (int i = 1; i < N_COLS - 1; i++) q[i] <= q[i-1];
      end
    end

    for (genvar c = 1; c < N_COLS; c++) begin : g_tap
      assign col_o[c] = q[c-1];
    end
  end
endmodule

// File: rtl/fir_shift_add.sv
module fir_shift_add #(
  parameter int W_X    = 8,
  parameter int W_P    = 16,
  parameter int COEF_W = 8,
  parameter int MAG    = 13
) (
  input  logic signed [W_X-1:0] x_i,
  output logic signed [W_P-1:0] p_o
);
  logic signed [W_P-1:0] xe;
  assign xe = {{(W_P-W_X){x_i[W_X-1]}}, x_i};

  // constant bits fold away: one adder per set bit, shifts are wiring
  always_comb begin
    p_o = '0;
    for (int b = 0; b < COEF_W; b++)
      if (((MAG >> b) & 1) != 0) p_o = p_o + (xe <<< b);
  end
endmodule

// File: rtl/fir_local_tree.sv
module fir_local_tree #(
  parameter int N_IN = 2,
  parameter int W_IN = 16,
  parameter int W_S  = 12
) (
  input  logic signed [W_IN-1:0] in_i [N_IN],
  output logic signed [W_S-1:0]  sum_o
);
  localparam int P = (N_IN <= 1) ? 1 : (1 << $clog2(N_IN));

  logic signed [W_S-1:0] node [2*P-1];

  for (genvar j = 0; j < P; j++) begin : g_leaf
    if (j < N_IN) begin : g_used
      assign node[P-1+j] = W_S'(in_i[j]);
    end else begin : g_pad
      assign node[P-1+j] = '0;
    end
  end

  for (genvar i = 0; i < P - 1; i++) begin : g_add
    assign node[i] = node[2*i+1] + node[2*i+2];
  end

  assign sum_o = node[0];
endmodule

// File: rtl/fir_grouped.sv
module fir_grouped
  import fir_grp_pkg::*;
#(
  parameter int    W_X    = 8,
  parameter int    N_TAPS = 9,
  parameter int    L      = 2,
  parameter int    COEF_W = 8,
  parameter coef_t COEF   = '{0: 6, 1: 13, 2: 22, 3: -28, 4: 50, 5: -28, 6: 22, 7: 13, 8: 6,
                              default: 0},
  localparam int   W_Y    = acc_width(W_X, abs_sum(COEF, 0, N_TAPS - 1))
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic signed [W_X-1:0] x_i,
  output logic                  valid_o,
  output logic signed [W_Y-1:0] y_o
);
  localparam int N_COLS = num_cols(L);
  localparam int N_GRP  = num_groups(N_TAPS, L);
  localparam int W_P    = W_X + COEF_W;

  logic signed [W_X-1:0] x_col [N_COLS];
  logic signed [W_P-1:0] mag_p [N_TAPS];
  logic signed [W_P-1:0] s_p   [N_TAPS];
  logic signed [W_Y-1:0] chain [N_GRP];

  fir_col_delay #(.W_X(W_X), .N_COLS(N_COLS)) u_cols (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (valid_i),
    .x_i   (x_i),
    .col_o (x_col)
  );

  for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
    localparam int OWN = tap_owner(COEF, k, L);
    localparam int COL = tap_col(k, L);
    if (OWN == k) begin : g_mul
      fir_shift_add #(.W_X(W_X), .W_P(W_P), .COEF_W(COEF_W), .MAG(iabs(COEF[k]))) u_mul (
        .x_i(x_col[COL]),
        .p_o(mag_p[k])
      );
    end else begin : g_reuse
      assign mag_p[k] = mag_p[OWN];
    end
    assign s_p[k] = (COEF[k] < 0) ? -mag_p[k] : mag_p[k];
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    localparam int F   = grp_first(g, L);
    localparam int LST = grp_last(g, N_TAPS, L);
    localparam int NG  = LST - F + 1;
    localparam int W_G = acc_width(W_X, abs_sum(COEF, F, LST));

    logic signed [W_P-1:0] leaf [NG];
    logic signed [W_G-1:0] gsum;

    for (genvar j = 0; j < NG; j++) begin : g_leaf
      assign leaf[j] = s_p[F+j];
    end

    fir_local_tree #(.N_IN(NG), .W_IN(W_P), .W_S(W_G)) u_tree (
      .in_i (leaf),
      .sum_o(gsum)
    );

    if (g == N_GRP - 1) begin : g_tail
      assign chain[g] = W_Y'(gsum);
    end else begin : g_link
      // delay between group starts keeps every tap aligned to its sample
      localparam int D = grp_first(g + 1, L) - F;
      logic signed [W_Y-1:0] dly [D];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < D; i++) dly[i] <= '0;
        end else if (valid_i) begin
          dly[0] <= chain[g+1];
          for (int i = 1; i < D; i++) dly[i] <= dly[i-1];
        end
      end

      assign chain[g] = W_Y'(gsum) + dly[D-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) y_o <= chain[0];
    end
  end
endmodule

// File: rtl/fir_grouped_chk.sv
module fir_grouped_chk
  import fir_grp_pkg::*;
#(
  parameter int    W_X    = 8,
  parameter int    W_Y    = 17,
  parameter int    N_TAPS = 9,
  parameter coef_t COEF   = '{default: 0}
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  valid_i,
  input logic signed [W_X-1:0] x_i,
  input logic                  valid_o,
  input logic signed [W_Y-1:0] y_o
);
  localparam longint MAXV = (longint'(1) << (W_X - 1)) * longint'(abs_sum(COEF, 0, N_TAPS - 1));

  logic unused_x;
  assign unused_x = ^x_i;

  p_vld_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_vld_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(y_o));

  p_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (longint'(y_o) <= MAXV) && (longint'(y_o) >= -MAXV));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_r4: assert (valid_o == 1'b0 && y_o == '0);
    end
  end
endmodule

bind fir_grouped fir_grouped_chk #(
  .W_X   (W_X),
  .W_Y   (W_Y),
  .N_TAPS(N_TAPS),
  .COEF  (COEF)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .x_i    (x_i),
  .valid_o(valid_o),
  .y_o    (y_o)
);

// File: tb/fir_grouped_tb_top.sv
module fir_grouped_tb_top;
  import fir_grp_pkg::*;

  localparam int    W_X = 8;
  localparam int    NT  = 9;
  localparam coef_t CF  = '{0: 6, 1: 13, 2: 22, 3: -28, 4: 50, 5: -28, 6: 22, 7: 13, 8: 6,
                            default: 0};
  localparam int    W_Y = acc_width(W_X, abs_sum(CF, 0, NT - 1));

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic signed [W_X-1:0] x_i = '0;

  logic v1, v2, v4, v9;
  logic signed [W_Y-1:0] y1, y2, y4, y9;

  always #5 clk = ~clk;

  fir_grouped #(.W_X(W_X), .N_TAPS(NT), .L(1), .COEF(CF)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .x_i(x_i), .valid_o(v1), .y_o(y1));
  fir_grouped #(.W_X(W_X), .N_TAPS(NT), .L(2), .COEF(CF)) dut_l2_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .x_i(x_i), .valid_o(v2), .y_o(y2));
  fir_grouped #(.W_X(W_X), .N_TAPS(NT), .L(4), .COEF(CF)) dut_l4_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .x_i(x_i), .valid_o(v4), .y_o(y4));
  fir_grouped #(.W_X(W_X), .N_TAPS(NT), .L(NT), .COEF(CF)) dut_l9_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .x_i(x_i), .valid_o(v9), .y_o(y9));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int hist [NT];
  int exp_y = 0;
  bit exp_v = 1'b0;
  string phase = "R4";

  task automatic chk_one(string tag, int l, logic v, logic signed [W_Y-1:0] y);
    n_chk++;
    if (v !== exp_v) begin
      n_fail++;
      $display("FAIL R2 (%s, L=%0d): valid=%0b expected %0b", tag, l, v, exp_v);
    end
    n_chk++;
    if (int'(y) != exp_y) begin
      n_fail++;
      $display("FAIL %s/R1 (%s, L=%0d): y=%0d expected %0d", phase, tag, l, int'(y), exp_y);
    end
  endtask

  task automatic chk_all();
    chk_one("R5", 1, v1, y1);
    chk_one("R6", 2, v2, y2);
    chk_one("R7", 4, v4, y4);
    chk_one("R9", NT, v9, y9);
  endtask

  // called at a falling edge; checks after the next rising edge
  task automatic step(bit v, int x);
    valid_i = v;
    x_i = W_X'(x);
    if (v) begin
      for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
      exp_y = 0;
      for (int k = 0; k < NT; k++) exp_y += CF[k] * hist[k];
    end
    exp_v = v;
    @(posedge clk);
    @(negedge clk);
    chk_all();
  endtask

  task automatic do_reset();
    phase = "R4";
    rst_ni = 1'b0;
    valid_i = 1'b1;
    x_i = 8'sd77;
    for (int k = 0; k < NT; k++) hist[k] = 0;
    exp_y = 0;
    exp_v = 1'b0;
    repeat (2) begin
      @(posedge clk);
      @(negedge clk);
      chk_all();
    end
    valid_i = 1'b0;
    rst_ni = 1'b1;
  endtask

  initial begin
    for (int k = 0; k < NT; k++) hist[k] = 0;
    @(negedge clk);
    do_reset();

    // R1: impulse gives the coefficients back, then random data
    phase = "R1";
    step(1, 1);
    for (int i = 0; i < NT + 2; i++) step(1, 0);
    step(1, -1);
    for (int i = 0; i < NT; i++) step(1, 0);
    for (int i = 0; i < 40; i++) step(1, int'($urandom_range(0, 255)) - 128);

    // R3: idle cycles carry random data that must be ignored
    phase = "R3";
    for (int i = 0; i < 80; i++)
      step(($urandom_range(0, 1) == 1), int'($urandom_range(0, 255)) - 128);

    // R2: isolated strobes
    phase = "R2";
    for (int i = 0; i < 6; i++) begin
      step(1, int'($urandom_range(0, 255)) - 128);
      step(0, 99);
      step(0, -99);
    end

    // R8: full-scale patterns aligned to coefficient signs, both polarities
    phase = "R8";
    for (int k = NT - 1; k >= 0; k--) step(1, (CF[k] > 0) ? 127 : -128);
    for (int k = NT - 1; k >= 0; k--) step(1, (CF[k] > 0) ? -128 : 127);
    for (int i = 0; i < 20; i++) step(1, ($urandom_range(0, 1) == 1) ? 127 : -128);

    // R4: reset in the middle of a run
    for (int i = 0; i < 5; i++) step(1, int'($urandom_range(0, 255)) - 128);
    do_reset();
    phase = "R4";
    for (int i = 0; i < NT + 3; i++) step(1, int'($urandom_range(0, 255)) - 128);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule